// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block is a station-management master for the two-wire MII management bus. Software loads one 32-bit frame word that holds the start code, the operation, a 5-bit PHY address, a 5-bit register address, the turnaround pattern and 16 data bits. The engine then clocks a complete clause-22 transaction onto MDC/MDIO, with an output enable for the external tri-state pad. Bit 16 of the same word is a completion flag, so software can poll that one location. When a read finishes, the word also returns the data the PHY sent.

A hardware polling mode runs without software. When it is enabled, and no software frame is waiting, the engine issues back-to-back reads of one selected PHY register. It keeps the most recent value and collects, in sticky change bits, every bit that differed between two consecutive results. A per-bit mask decides which of those change bits drive the interrupt output. MDC is divided down from the system clock by a run-time half-period value.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset the frame word reads 0x0001_0000 (flag set, idle), MDC and the output enable are low, and the poll status and interrupt are zero.
- R2: Every transaction is 64 MDC periods long: 32 ones, then frame-word bits 31 down to 0, MSB first. MDIO changes only after a falling MDC edge and never while MDC is high.
- R3: An operation code of 2'b10 in frame bits 29:28 is a read. The output enable is low from wire bit 46 (the first turnaround bit) to the end. The 16 bits sampled on the rising MDC edges of wire bits 48..63 are returned in frame bits 15:0, MSB first.
- R4: Any other operation code (write is 2'b01) drives all 64 bits, including the turnaround taken from frame bits 17:16. Frame bits 15:0 keep the written data after completion.
- R5: An accepted load clears bit 16. With the engine idle and polling off, bit 16 reads 1 again exactly 128·H+3 clock edges after the load edge, where H is the effective half period.
- R6: A load issued while bit 16 is 0 is ignored. The frame word and the bus transaction are unaffected.
- R7: MDC high and low phases each last H clock cycles, where H is the mdc_half input and values below 2 are taken as 2. When no transaction runs, MDC is low and the output enable is low.
- R8: With poll_en high, the engine repeatedly reads register poll_reg of PHY poll_phy using start 01, opcode 10 and turnaround 10. The latest result appears in poll_stat[31:16].
- R9: poll_stat[15:0] accumulates, sticky, the XOR of each two consecutive poll results. The first result after polling is enabled marks no change. A poll_clr pulse clears these bits.
- R10: poll_irq is high one cycle after any change bit whose poll_mask bit is 0 is set. A mask bit of 1 blocks that bit.
- R11: A pending software frame is issued before the next poll frame. Poll frames never modify the frame word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_wr | input | 1 | Load pulse for the frame word |
| frm_wdata | input | 32 | Frame word to load |
| frm_rdata | output | 32 | Frame word view; bit 16 is the completion flag |
| mdc_half | input | DIV_W | MDC half period in clock cycles (minimum 2) |
| poll_en | input | 1 | Enable hardware polling |
| poll_phy | input | 5 | PHY address for polling |
| poll_reg | input | 5 | Register address for polling |
| poll_mask | input | 16 | Per-bit interrupt block (1 = blocked) |
| poll_clr | input | 1 | Clears the sticky change bits |
| poll_stat | output | 32 | {last poll value, change bits} |
| poll_irq | output | 1 | Change interrupt |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO pad input |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
A bus responder on the bench first writes every one of the 32 registers of one PHY with data computed from the address, then reads each back. This separates the address-field and data-order logic from simple stuck patterns, and a read of an absent PHY shows pull-up ones and a released turnaround. Three half-period settings (0, 2 and 5) measure the MDC phases and pin down the exact completion cycle. A store issued during an active frame shows that the loading rule works. Polling is driven through value steps chosen to land in masked and in unmasked bits, which separates sticky accumulation, masking, clearing and the quiet first sample. A software read issued while polling is running shows arbitration and that the frame word is kept apart from poll results.

// File: rtl/mdio_eng_pkg.sv
package mdio_eng_pkg;
  localparam int FRAME_W   = 32;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 5;
  localparam int IDX_W     = 6;
  localparam logic [IDX_W-1:0] TA_IDX   = 6'd46;
  localparam logic [IDX_W-1:0] LAST_IDX = 6'd63;
  localparam logic [1:0] START_CODE = 2'b01;
  localparam logic [1:0] OP_RD      = 2'b10;
  localparam logic [1:0] TURN_CODE  = 2'b10;
  localparam int FLAG_BIT = 16;
  localparam logic [FRAME_W-1:0] FLAG_MASK = 32'h0001_0000;

  function automatic logic [FRAME_W-1:0] poll_word(input logic [ADDR_W-1:0] phy,
                                                   input logic [ADDR_W-1:0] rg);
    return {START_CODE, OP_RD, phy, rg, TURN_CODE, {DATA_W{1'b0}}};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] half,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  always_comb lim = (half < MIN_HALF) ? MIN_HALF : half;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      mdc  <= 1'b0;
      rise <= 1'b0;
      fall <= 1'b0;
    end else if (cnt == lim - 1'b1) begin
      cnt  <= '0;
      mdc  <= ~mdc;
      rise <= ~mdc;
      fall <= mdc;
    end else begin
      cnt  <= cnt + 1'b1;
      rise <= 1'b0;
      fall <= 1'b0;
    end
  end

  assert_edges_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(rise && fall));
  assert_idle_low_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !mdc);
endmodule

// File: rtl/mdio_serdes.sv
module mdio_serdes
  import mdio_eng_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic               rise,
  input  logic               fall,
  input  logic               mdio_i,
  output logic               busy,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               done,
  output logic [DATA_W-1:0]  rdata
);
  logic [IDX_W-1:0]   idx;
  logic [IDX_W-1:0]   nidx;
  logic               tail;
  logic               is_rd;
  logic [FRAME_W-1:0] frm;
  logic               nbit;

  always_comb begin
    nidx = idx + 6'd1;
    nbit = nidx[IDX_W-1] ? frm[~nidx[IDX_W-2:0]] : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      idx     <= '0;
      tail    <= 1'b0;
      is_rd   <= 1'b0;
      frm     <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy    <= 1'b1;
        idx     <= '0;
        tail    <= 1'b0;
        frm     <= frame;
        is_rd   <= (frame[29:28] == OP_RD);
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b1;
      end else if (busy) begin
        if (rise) begin
          rdata <= {rdata[DATA_W-2:0], mdio_i};
          if (idx == LAST_IDX) tail <= 1'b1;
        end
        if (fall) begin
          if (tail) begin
            busy    <= 1'b0;
            tail    <= 1'b0;
            done    <= 1'b1;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
          end else begin
            idx     <= nidx;
            mdio_o  <= nbit;
            mdio_oe <= !(is_rd && (nidx >= TA_IDX));
          end
        end
      end
    end
  end

  assert_released_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);
  assert_read_released_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && is_rd && idx >= TA_IDX) |-> !mdio_oe);
  assert_hold_after_fall_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !fall) |=> $stable(mdio_o));
endmodule

// File: rtl/mdio_poll_track.sv
module mdio_poll_track
  import mdio_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              res_vld,
  input  logic [DATA_W-1:0] res,
  input  logic              clr,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] last,
  output logic [DATA_W-1:0] chg,
  output logic              irq
);
  logic              primed;
  logic [DATA_W-1:0] chg_n;

  always_comb begin
    chg_n = clr ? '0 : chg;
    if (res_vld && en && primed) chg_n = chg_n | (last ^ res);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last   <= '0;
      chg    <= '0;
      irq    <= 1'b0;
      primed <= 1'b0;
    end else begin
      chg <= chg_n;
      irq <= |(chg & ~mask);
      if (!en) begin
        primed <= 1'b0;
      end else if (res_vld) begin
        last   <= res;
        primed <= 1'b1;
      end
    end
  end

  assert_irq_needs_change_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(chg != '0));
  assert_first_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (res_vld && en && !primed && !clr) |=> $stable(chg));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_eng_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frm_wr,
  input  logic [31:0]        frm_wdata,
  output logic [31:0]        frm_rdata,
  input  logic [DIV_W-1:0]   mdc_half,
  input  logic               poll_en,
  input  logic [4:0]         poll_phy,
  input  logic [4:0]         poll_reg,
  input  logic [15:0]        poll_mask,
  input  logic               poll_clr,
  output logic [31:0]        poll_stat,
  output logic               poll_irq,
  output logic               mdc,
  input  logic               mdio_i,
  output logic               mdio_o,
  output logic               mdio_oe
);
  logic [FRAME_W-1:0] frame_q;
  logic               sw_pend;
  logic               own_sw;
  logic               start;
  logic [FRAME_W-1:0] start_word;
  logic               ser_busy;
  logic               ser_done;
  logic [DATA_W-1:0]  ser_rdata;
  logic               tick_rise;
  logic               tick_fall;
  logic [DATA_W-1:0]  p_last;
  logic [DATA_W-1:0]  p_chg;

  always_comb begin
    start      = !ser_busy && (sw_pend || poll_en);
    start_word = sw_pend ? frame_q : poll_word(poll_phy, poll_reg);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= FLAG_MASK;
      sw_pend <= 1'b0;
      own_sw  <= 1'b0;
    end else begin
      if (start) begin
        own_sw  <= sw_pend;
        sw_pend <= 1'b0;
      end
      if (ser_done && own_sw) begin
        frame_q[FLAG_BIT] <= 1'b1;
        if (frame_q[29:28] == OP_RD) frame_q[DATA_W-1:0] <= ser_rdata;
      end
      if (frm_wr && frame_q[FLAG_BIT]) begin
        frame_q <= frm_wdata & ~FLAG_MASK;
        sw_pend <= 1'b1;
      end
    end
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk (clk),
    .rst (rst),
    .en  (ser_busy),
    .half(mdc_half),
    .mdc (mdc),
    .rise(tick_rise),
    .fall(tick_fall)
  );

  mdio_serdes u_ser (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .frame  (start_word),
    .rise   (tick_rise),
    .fall   (tick_fall),
    .mdio_i (mdio_i),
    .busy   (ser_busy),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe),
    .done   (ser_done),
    .rdata  (ser_rdata)
  );

  mdio_poll_track u_poll (
    .clk    (clk),
    .rst    (rst),
    .en     (poll_en),
    .res_vld(ser_done && !own_sw),
    .res    (ser_rdata),
    .clr    (poll_clr),
    .mask   (poll_mask),
    .last   (p_last),
    .chg    (p_chg),
    .irq    (poll_irq)
  );

  assign frm_rdata = frame_q;
  assign poll_stat = {p_last, p_chg};

  assert_flag_falls_on_load_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_q[FLAG_BIT]) |-> $past(frm_wr));
  assert_busy_load_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (frm_wr && !frame_q[FLAG_BIT] && !(ser_done && own_sw)) |=> $stable(frame_q));
  assert_poll_keeps_word_R11: assert property (@(posedge clk) disable iff (rst)
    (ser_done && !own_sw && !frm_wr) |=> $stable(frame_q));
endmodule

// File: tb/sim_mdio_frame_engine.sv
`timescale 1ns/1ps
module sim_mdio_frame_engine;
  localparam logic [4:0] PHY_A = 5'd3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frm_wr = 1'b0;
  logic [31:0] frm_wdata = '0;
  logic [31:0] frm_rdata;
  logic [7:0]  mdc_half = 8'd2;
  logic        poll_en = 1'b0;
  logic [4:0]  poll_phy = '0;
  logic [4:0]  poll_reg = '0;
  logic [15:0] poll_mask = '1;
  logic        poll_clr = 1'b0;
  logic [31:0] poll_stat;
  logic        poll_irq;
  logic        mdc, mdio_i, mdio_o, mdio_oe;

  int total = 0, fails = 0;
  bit finished = 0;

  // bench PHY model state (owned by responder block)
  logic [15:0] phy_regs [32];
  logic [63:0] cap, last_cap;
  int bcnt, nframes, contention, hold_err, herr, hcnt, exp_h;
  logic pm, pmo, phy_en, phy_bit;
  logic poke_en = 1'b0;
  logic [4:0] poke_addr = '0;
  logic [15:0] poke_val = '0;

  always #4 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_frame_engine #(.DIV_W(8)) u0 (
    .clk(clk), .rst(rst), .frm_wr(frm_wr), .frm_wdata(frm_wdata), .frm_rdata(frm_rdata),
    .mdc_half(mdc_half), .poll_en(poll_en), .poll_phy(poll_phy), .poll_reg(poll_reg),
    .poll_mask(poll_mask), .poll_clr(poll_clr), .poll_stat(poll_stat), .poll_irq(poll_irq),
    .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always @(negedge clk) begin
    if (rst) begin
      bcnt = 0; nframes = 0; contention = 0; hold_err = 0; herr = 0; hcnt = 0;
      pm = 1'b0; pmo = 1'b1; phy_en = 1'b0; phy_bit = 1'b1; cap = '0; last_cap = '0;
      for (int i = 0; i < 32; i++) phy_regs[i] = 16'h0;
    end else begin
      if (poke_en) phy_regs[poke_addr] = poke_val;
      if (mdc && pmo != mdio_o) hold_err++;
      if (mdc) hcnt++;
      if (mdc && !pm) begin
        if (phy_en && mdio_oe) contention++;
        cap[63-bcnt] = mdio_i;
        bcnt++;
        if (bcnt == 64) begin
          bcnt = 0;
          last_cap = cap;
          nframes++;
          if (cap[29:28] == 2'b01 && cap[27:23] == PHY_A) phy_regs[cap[22:18]] = cap[15:0];
        end
      end
      if (!mdc && pm) begin
        if (hcnt != exp_h) herr++;
        hcnt = 0;
        phy_en = 1'b0;
        if (bcnt >= 47 && cap[29:28] == 2'b10 && cap[27:23] == PHY_A) begin
          phy_en = 1'b1;
          phy_bit = (bcnt == 47) ? 1'b0 : phy_regs[cap[22:18]][63-bcnt];
        end
      end
      pm = mdc;
      pmo = mdio_o;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fval(input int r);
    return 16'((r + 1) * 40503);
  endfunction

  function automatic logic [31:0] wr_word(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    return {2'b01, 2'b01, p, r, 2'b10, d};
  endfunction

  function automatic logic [31:0] rd_word(input logic [4:0] p, input logic [4:0] r);
    return {2'b01, 2'b10, p, r, 2'b10, 16'h0};
  endfunction

  task automatic run_frame(input logic [31:0] w, output int k);
    @(negedge clk); frm_wr = 1'b1; frm_wdata = w;
    @(negedge clk); frm_wr = 1'b0; k = 1;
    while (!frm_rdata[16] && k < 5000) begin @(negedge clk); k++; end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_frames(input int n);
    int s, t;
    s = nframes; t = 0;
    while (nframes < s + n && t < 5000) begin @(negedge clk); t++; end
  endtask

  task automatic poke(input logic [4:0] a, input logic [15:0] v);
    poke_addr = a; poke_val = v; poke_en = 1'b1;
    @(negedge clk); poke_en = 1'b0;
  endtask

  initial begin
    #1_600_000;
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int k, n0;
    logic [15:0] v;
    exp_h = 2;
    wait_cycles(4);
    rst = 1'b0;
    wait_cycles(2);
    // R1 reset state
    chk(frm_rdata == 32'h0001_0000, "R1 frame word", frm_rdata, 32'h0001_0000);
    chk(!mdc && !mdio_oe && !poll_irq, "R1 bus idle", {mdc, mdio_oe, poll_irq}, 0);
    chk(poll_stat == 0, "R1 poll status", poll_stat, 0);

    // R5/R4/R2 single write, exact latency
    run_frame(wr_word(PHY_A, 5'd0, 16'h1234), k);
    chk(k == 128*2 + 4, "R5 completion cycle", k, 128*2 + 4);
    chk(frm_rdata == {wr_word(PHY_A, 5'd0, 16'h1234) | 32'h0001_0000}, "R4 word after write",
        frm_rdata, wr_word(PHY_A, 5'd0, 16'h1234) | 32'h0001_0000);
    chk(last_cap == {32'hFFFF_FFFF, wr_word(PHY_A, 5'd0, 16'h1234)}, "R2 wire bits",
        last_cap, {32'hFFFF_FFFF, wr_word(PHY_A, 5'd0, 16'h1234)});

    // R4 sweep writes, R3 sweep reads
    for (int r = 0; r < 32; r++) begin
      run_frame(wr_word(PHY_A, 5'(r), fval(r)), k);
      chk(phy_regs[r] == fval(r) && frm_rdata[15:0] == fval(r), "R4 write sweep",
          {phy_regs[r], frm_rdata[15:0]}, {fval(r), fval(r)});
    end
    for (int r = 0; r < 32; r++) begin
      run_frame(rd_word(PHY_A, 5'(r)), k);
      chk(frm_rdata == (rd_word(PHY_A, 5'(r)) | 32'h0001_0000 | 32'(fval(r))), "R3 read sweep",
          frm_rdata, rd_word(PHY_A, 5'(r)) | 32'h0001_0000 | 32'(fval(r)));
      chk(last_cap == {32'hFFFF_FFFF, rd_word(PHY_A, 5'(r)) | 32'(fval(r))}, "R3 read wire",
          last_cap, {32'hFFFF_FFFF, rd_word(PHY_A, 5'(r)) | 32'(fval(r))});
    end
    chk(contention == 0, "R3 no drive in turnaround", contention, 0);
    run_frame(rd_word(5'd7, 5'd2), k);
    chk(frm_rdata[15:0] == 16'hFFFF && last_cap[17:16] == 2'b11, "R3 absent PHY",
        {frm_rdata[15:0], last_cap[17:16]}, {16'hFFFF, 2'b11});

    // R6 load during active frame
    n0 = nframes;
    @(negedge clk); frm_wr = 1'b1; frm_wdata = wr_word(PHY_A, 5'd20, 16'hBEEF);
    @(negedge clk); frm_wr = 1'b0;
    wait_cycles(20);
    frm_wr = 1'b1; frm_wdata = wr_word(PHY_A, 5'd21, 16'h1111);
    @(negedge clk); frm_wr = 1'b0;
    k = 0;
    while (!frm_rdata[16] && k < 5000) begin @(negedge clk); k++; end
    wait_cycles(400);
    chk(frm_rdata == (wr_word(PHY_A, 5'd20, 16'hBEEF) | 32'h0001_0000), "R6 word kept",
        frm_rdata, wr_word(PHY_A, 5'd20, 16'hBEEF) | 32'h0001_0000);
    chk(phy_regs[21] == fval(21) && nframes == n0 + 1, "R6 no second frame",
        {phy_regs[21], 16'(nframes - n0)}, {fval(21), 16'd1});

    // R7 half period clamp and stretch
    mdc_half = 8'd0;
    run_frame(rd_word(PHY_A, 5'd5), k);
    chk(k == 128*2 + 4, "R7 clamp to 2", k, 128*2 + 4);
    mdc_half = 8'd5; exp_h = 5;
    run_frame(rd_word(PHY_A, 5'd6), k);
    chk(k == 128*5 + 4 && frm_rdata[15:0] == fval(6), "R7 half period 5",
        {16'(k), frm_rdata[15:0]}, {16'(128*5 + 4), fval(6)});
    chk(herr == 0, "R7 phase lengths", herr, 0);
    chk(hold_err == 0, "R2 mdio stable while mdc high", hold_err, 0);
    mdc_half = 8'd2; exp_h = 2;
    wait_cycles(4);
    chk(!mdc && !mdio_oe, "R7 idle bus", {mdc, mdio_oe}, 0);

    // R8/R9/R10 polling
    poke(5'd4, 16'h00F0);
    poll_mask = 16'hFF00; poll_phy = PHY_A; poll_reg = 5'd4; poll_en = 1'b1;
    wait_frames(2); wait_cycles(10);
    chk(poll_stat[31:16] == 16'h00F0, "R8 last value", poll_stat[31:16], 16'h00F0);
    chk(last_cap == {32'hFFFF_FFFF, rd_word(PHY_A, 5'd4) | 32'h00F0}, "R8 poll wire",
        last_cap, {32'hFFFF_FFFF, rd_word(PHY_A, 5'd4) | 32'h00F0});
    chk(poll_stat[15:0] == 0 && !poll_irq, "R9 first result quiet", {poll_stat[15:0], poll_irq}, 0);
    wait_frames(1); poke(5'd4, 16'h0FF0);
    wait_frames(2); wait_cycles(10);
    chk(poll_stat[15:0] == 16'h0F00, "R9 change bits", poll_stat[15:0], 16'h0F00);
    chk(!poll_irq, "R10 masked change", poll_irq, 0);
    wait_frames(1); poke(5'd4, 16'h0FF1);
    wait_frames(2); wait_cycles(10);
    chk(poll_stat[15:0] == 16'h0F01, "R9 sticky accumulate", poll_stat[15:0], 16'h0F01);
    chk(poll_irq, "R10 unmasked change", poll_irq, 1);
    @(negedge clk); poll_clr = 1'b1; @(negedge clk); poll_clr = 1'b0;
    wait_cycles(3);
    chk(poll_stat[15:0] == 0 && !poll_irq, "R9 clear", {poll_stat[15:0], poll_irq}, 0);
    poll_mask = 16'h0000;
    wait_cycles(3);
    chk(!poll_irq, "R10 no change no irq", poll_irq, 0);
    wait_frames(1); poke(5'd4, 16'h8FF1);
    wait_frames(2); wait_cycles(10);
    chk(poll_stat[15:0] == 16'h8000 && poll_irq, "R10 top bit", {poll_stat[15:0], poll_irq}, {16'h8000, 1'b1});

    // R11 software frame while polling
    run_frame(rd_word(PHY_A, 5'd9), k);
    chk(k <= 2*(128*2 + 2) + 8 && frm_rdata[15:0] == fval(9), "R11 software precedence",
        {16'(k), frm_rdata[15:0]}, {16'(2*(128*2 + 2) + 8), fval(9)});
    v = frm_rdata[15:0];
    wait_frames(2); wait_cycles(10);
    chk(frm_rdata[15:0] == v && poll_stat[31:16] == 16'h8FF1, "R11 poll keeps word",
        {frm_rdata[15:0], poll_stat[31:16]}, {v, 16'h8FF1});

    poll_en = 1'b0;
    wait_cycles(600);
    n0 = nframes;
    wait_cycles(300);
    chk(nframes == n0 && !mdc && !mdio_oe, "R7 idle after polling",
        {16'(nframes - n0), mdc, mdio_oe}, 0);
    chk(contention == 0 && hold_err == 0 && herr == 0, "R2 bus rules overall",
        {contention[15:0], hold_err[15:0], herr[15:0]}, 0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule